// File: doc/BRIEF.md
# Strap-Configured Microprocessor Bus Slave Adapter

This block lets a small 8/16-bit microprocessor reach a 12-bit word-address space inside the chip. On every cycle qualified by chip select, the block latches an address and decodes a read or a write. It optionally exchanges the two bytes of each 16-bit data word. It then returns an active-low acknowledge. It also forwards an internal interrupt request to the processor as an active-low line. A small memory-mapped word store stands in for the internal registers and buffers. It has a fixed read pipeline latency.

The processor bus can take several forms, and four strap inputs select among them. These straps are captured only around reset. One strap chooses between a shared address/data lane and separate lanes. One chooses whether bytes are swapped. One chooses between early acknowledge and acknowledge on valid read data. One chooses synchronous or asynchronous operation. In asynchronous operation the bus strobes are re-timed through a two-flop synchronizer, and the acknowledge is held until the processor releases its strobe. In synchronous operation the acknowledge is a single-clock pulse.

Top module: `cpu_bus_slave`

## Requirements
- R1: While `addr_latch_ni` is low at a rising clock edge, the address is captured: from `ad_i[11:0]` when the shared-lane strap is 1, from `addr_i` when it is 0. The backing store decodes only the low `MEM_AW` address bits (64 words by default), so addresses that differ only above those bits alias.
- R2: The straps are captured on every clock edge while reset is active and on the first edge after release. Any later change on the strap pins has no effect on behaviour.
- R3: When the swap strap is 1, bits [15:8] and [7:0] are exchanged on write data going into the store and on read data coming out of it. When it is 0, data passes unchanged.
- R4: In synchronous mode the strobes are registered once. If a strobe is low before clock edge k, `ack_no` goes low after edge k+1 and returns high after edge k+2, even if the strobe is still held.
- R5: In asynchronous mode the strobes pass through two flops, so `ack_no` goes low one edge later than in R4. It then stays low until the released strobe has crossed the synchronizer. It goes high three edges after the release.
- R6: With the late-acknowledge strap at 1, a read is acknowledged one edge later than in R4/R5, on the same edge the read data becomes valid after the 2-cycle store latency. Write acknowledge timing is unchanged.
- R7: `ad_oe_o` is 1 exactly while `cs_ni` and `rd_ni` are both low. During an acknowledged read, from the cycle after the acknowledge, `ad_o` carries the addressed word.
- R8: A write strobe with `cs_ni` high produces no acknowledge and leaves the store unchanged.
- R9: `irq_no` equals the inverse of `irq_i` one clock later.
- R10: After reset, `ack_no` and `irq_no` are 1 and `ad_oe_o` is 0 while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interface clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap_muxed_i | input | 1 | 1: address shares the data lane |
| strap_swap_i | input | 1 | 1: exchange data bytes |
| strap_ack_late_i | input | 1 | 1: read acknowledge waits for data |
| strap_async_i | input | 1 | 1: asynchronous bus, strobes synchronized |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_latch_ni | input | 1 | Address latch strobe, active low |
| addr_i | input | 12 | Separate address lane |
| ad_i | input | 16 | Data lane in (address too in shared mode) |
| ad_o | output | 16 | Read data out |
| ad_oe_o | output | 1 | Output enable for the data lane |
| ack_no | output | 1 | Transfer acknowledge, active low |
| irq_i | input | 1 | Internal interrupt request, active high |
| irq_no | output | 1 | Interrupt to processor, active low |

## Verification
The hardest situation to reach is a change of strap settings. The straps only take effect through a reset, so most configurations never show up in a plain run. The stimulus therefore cycles through all sixteen strap combinations with a reset before each one. After every reset release it drives the strap pins to the opposite values. Each timing check then also shows that the pins are ignored after reset. The store is never cleared, so a word written under one swap setting is read back under the other to expose the byte exchange.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_ACK, ST_HOLD} xfer_st_e;

  typedef struct packed {
    logic muxed;
    logic swap;
    logic ack_late;
    logic async;
  } strap_t;

  function automatic logic [DW-1:0] lane_swap(input logic [DW-1:0] d, input logic en);
    return en ? {d[7:0], d[15:8]} : d;
  endfunction
endpackage

// File: rtl/cbs_strobe_sync.sv
module cbs_strobe_sync #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         async_i,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] f1_q, f2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f1_q <= '0;
      f2_q <= '0;
    end else begin
      f1_q <= raw_i;
      f2_q <= f1_q;
    end
  end

  // async: second stage for metastability settling
  assign sync_o = async_i ? f2_q : f1_q;
endmodule

// File: rtl/cbs_backend.sv
module cbs_backend #(
  parameter int AW       = 12,
  parameter int MEM_AW   = 6,
  parameter int DW       = 16,
  parameter int READ_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [DW-1:0] mem [DEPTH];
  logic [MEM_AW-1:0] idx;
  logic [READ_LAT-1:0][DW-1:0] dpipe;
  logic [READ_LAT-1:0] vpipe;

  assign idx = addr_i[MEM_AW-1:0];

  generate
    if (MEM_AW < AW) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^addr_i[AW-1:MEM_AW];
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (we_i) mem[idx] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dpipe <= '0;
      vpipe <= '0;
    end else begin
      vpipe <= {vpipe[READ_LAT-2:0], re_i};
      if (re_i) dpipe[0] <= mem[idx];
      for (int i = 1; i < READ_LAT; i++) begin
        if (vpipe[i-1]) dpipe[i] <= dpipe[i-1];
      end
    end
  end

  assign rdata_o  = dpipe[READ_LAT-1];
  assign rvalid_o = vpipe[READ_LAT-1];
endmodule

// File: rtl/cbs_xfer_ctrl.sv
module cbs_xfer_ctrl
  import cbs_pkg::*;
#(
  parameter int READ_LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  input  logic ack_late_i,
  input  logic req_rd_i,
  input  logic req_wr_i,
  output logic we_o,
  output logic re_o,
  output logic ack_o
);
  localparam int CW = $clog2(READ_LAT + 1);

  xfer_st_e st_q;
  logic [CW-1:0] cnt_q;
  logic ack_q;
  logic req_any;

  assign req_any = req_rd_i | req_wr_i;

  always_comb begin
    we_o = (st_q == ST_IDLE) && req_wr_i;
    re_o = (st_q == ST_IDLE) && req_rd_i && !req_wr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ack_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (req_wr_i) begin
            ack_q <= 1'b1;
            st_q  <= ST_ACK;
          end else if (req_rd_i) begin
            if (ack_late_i) begin
              cnt_q <= CW'(READ_LAT - 1);
              st_q  <= ST_WAIT;
            end else begin
              ack_q <= 1'b1;
              st_q  <= ST_ACK;
            end
          end
        end
        ST_WAIT: begin
          if (cnt_q == CW'(1)) begin
            ack_q <= 1'b1;
            st_q  <= ST_ACK;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_ACK: begin
          if (async_i) begin
            if (!req_any) begin
              ack_q <= 1'b0;
              st_q  <= ST_IDLE;
            end
          end else begin
            ack_q <= 1'b0;
            st_q  <= req_any ? ST_HOLD : ST_IDLE;
          end
        end
        default: begin
          if (!req_any) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign ack_o = ack_q;

  p_early_ack_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_q) && !ack_late_i |-> $past(req_any));

  p_sync_ack_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q && !async_i |=> !ack_q);

  p_async_ack_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q && async_i && req_any |=> ack_q);
endmodule

// File: rtl/cpu_bus_slave.sv
module cpu_bus_slave
  import cbs_pkg::*;
#(
  parameter int AW       = 12,
  parameter int MEM_AW   = 6,
  parameter int READ_LAT = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          strap_muxed_i,
  input  logic          strap_swap_i,
  input  logic          strap_ack_late_i,
  input  logic          strap_async_i,
  input  logic          cs_ni,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic          addr_latch_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe_o,
  output logic          ack_no,
  input  logic          irq_i,
  output logic          irq_no
);
  strap_t strap_q;
  logic rst_q;
  logic [AW-1:0] addr_q;
  logic [2:0] strobe_s;
  logic req_rd, req_wr;
  logic be_we, be_re, be_rvalid, ack;
  logic [DW-1:0] be_rdata;
  logic irq_q;

  // straps follow the pins until the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= 1'b1;
    else         rst_q <= 1'b0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_q) strap_q <= '{muxed: strap_muxed_i, swap: strap_swap_i,
                            ack_late: strap_ack_late_i, async: strap_async_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             addr_q <= '0;
    else if (!addr_latch_ni) addr_q <= strap_q.muxed ? ad_i[AW-1:0] : addr_i;
  end

  cbs_strobe_sync #(.N(3)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (strap_q.async),
    .raw_i   ({~cs_ni, ~rd_ni, ~wr_ni}),
    .sync_o  (strobe_s)
  );

  assign req_rd = strobe_s[2] & strobe_s[1];
  assign req_wr = strobe_s[2] & strobe_s[0];

  cbs_xfer_ctrl #(.READ_LAT(READ_LAT)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .async_i    (strap_q.async),
    .ack_late_i (strap_q.ack_late),
    .req_rd_i   (req_rd),
    .req_wr_i   (req_wr),
    .we_o       (be_we),
    .re_o       (be_re),
    .ack_o      (ack)
  );

  cbs_backend #(.AW(AW), .MEM_AW(MEM_AW), .DW(DW), .READ_LAT(READ_LAT)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (be_we),
    .re_i     (be_re),
    .addr_i   (addr_q),
    .wdata_i  (lane_swap(ad_i, strap_q.swap)),
    .rdata_o  (be_rdata),
    .rvalid_o (be_rvalid)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b1;
    else         irq_q <= ~irq_i;
  end

  assign ad_o    = lane_swap(be_rdata, strap_q.swap);
  assign ad_oe_o = ~cs_ni & ~rd_ni;
  assign ack_no  = ~ack;
  assign irq_no  = irq_q;

  p_strap_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_q |=> $stable(strap_q));

  p_late_ack_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack) && strap_q.ack_late && !$past(be_we) |-> be_rvalid);

  p_we_sync_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_we && !strap_q.async |-> !$past(cs_ni));

  p_we_async_cs_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    be_we && strap_q.async |-> !$past(cs_ni, 2));

  p_irq_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_no);

  p_irq_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i |=> irq_no);
endmodule

// File: tb/cpu_bus_slave_tb_top.sv
module cpu_bus_slave_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_ni, strap_muxed_i, strap_swap_i, strap_ack_late_i, strap_async_i;
  logic cs_ni, rd_ni, wr_ni, addr_latch_ni, ad_oe_o, ack_no, irq_i, irq_no;
  logic [11:0] addr_i;
  logic [15:0] ad_i, ad_o;

  int total = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] model [64];
  bit c_mux, c_swap, c_late, c_async;

  cpu_bus_slave dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .strap_muxed_i(strap_muxed_i), .strap_swap_i(strap_swap_i),
    .strap_ack_late_i(strap_ack_late_i), .strap_async_i(strap_async_i),
    .cs_ni(cs_ni), .rd_ni(rd_ni), .wr_ni(wr_ni), .addr_latch_ni(addr_latch_ni),
    .addr_i(addr_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .ack_no(ack_no), .irq_i(irq_i), .irq_no(irq_no)
  );

  function automatic logic [15:0] swp(input logic [15:0] d, input bit en);
    return en ? {d[7:0], d[15:8]} : d;
  endfunction

  function automatic int exp_lat(input bit is_rd);
    return 2 + int'(c_async) + int'(c_late && is_rd);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit m, input bit s, input bit l, input bit a);
    @(negedge clk);
    strap_muxed_i = m; strap_swap_i = s; strap_ack_late_i = l; strap_async_i = a;
    rst_ni = 0; cs_ni = 1; rd_ni = 1; wr_ni = 1; addr_latch_ni = 1; irq_i = 0;
    repeat (4) @(negedge clk);
    rst_ni = 1;
    c_mux = m; c_swap = s; c_late = l; c_async = a;
    @(negedge clk);
    // R2: pins now disagree with the captured straps
    strap_muxed_i = !m; strap_swap_i = !s; strap_ack_late_i = !l; strap_async_i = !a;
    @(negedge clk);
    chk(ack_no == 1'b1, "R10 ack idle", 16'(ack_no), 16'h1);
    chk(irq_no == 1'b1, "R10 irq idle", 16'(irq_no), 16'h1);
    chk(ad_oe_o == 1'b0, "R10 oe idle", 16'(ad_oe_o), 16'h0);
  endtask

  task automatic addr_phase(input logic [11:0] a, input logic csn);
    @(negedge clk);
    addr_latch_ni = 0; cs_ni = csn;
    if (c_mux) begin ad_i = {4'($urandom), a}; addr_i = 12'($urandom); end
    else begin addr_i = a; ad_i = 16'($urandom); end
    @(negedge clk);
    addr_latch_ni = 1;
  endtask

  task automatic wait_ack(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (ack_no && n < 12);
  endtask

  task automatic release_bus();
    int n = 0;
    rd_ni = 1; wr_ni = 1; cs_ni = 1;
    while (!ack_no && n < 8) begin @(negedge clk); n++; end
    chk(ack_no == 1'b1, "R5 ack released", 16'(ack_no), 16'h1);
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [15:0] d, output int lat);
    addr_phase(a, 1'b0);
    ad_i = d; wr_ni = 0;
    #1 chk(ad_oe_o == 1'b0, "R7 no drive on write", 16'(ad_oe_o), 16'h0);
    wait_ack(lat);
    chk(lat == exp_lat(0), c_async ? "R5 write ack latency" : "R4 write ack latency",
        16'(lat), 16'(exp_lat(0)));
    @(negedge clk);
    chk(ack_no == !c_async, c_async ? "R5 ack held" : "R4 ack pulse", 16'(ack_no), 16'(!c_async));
    release_bus();
    model[a[5:0]] = swp(d, c_swap);
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [15:0] v);
    int lat;
    addr_phase(a, 1'b0);
    rd_ni = 0;
    wait_ack(lat);
    chk(lat == exp_lat(1), c_late ? "R6 read ack latency" : "R4 read ack latency",
        16'(lat), 16'(exp_lat(1)));
    @(negedge clk);
    chk(ack_no == !c_async, c_async ? "R5 read ack held" : "R4 read ack pulse",
        16'(ack_no), 16'(!c_async));
    chk(ad_oe_o == 1'b1, "R7 drive on read", 16'(ad_oe_o), 16'h1);
    v = ad_o;
    chk(v == swp(model[a[5:0]], c_swap), "R7 read data", v, swp(model[a[5:0]], c_swap));
    release_bus();
  endtask

  task automatic ignored_write(input logic [11:0] a, input logic [15:0] d);
    int lows = 0;
    addr_phase(a, 1'b1);
    ad_i = d; wr_ni = 0;
    repeat (5) begin @(negedge clk); if (!ack_no) lows++; end
    chk(lows == 0, "R8 no ack without select", 16'(lows), 16'h0);
    wr_ni = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic irq_check();
    @(negedge clk); irq_i = 1;
    @(negedge clk); chk(irq_no == 1'b0, "R9 irq set", 16'(irq_no), 16'h0);
    irq_i = 0;
    @(negedge clk); chk(irq_no == 1'b1, "R9 irq clear", 16'(irq_no), 16'h1);
  endtask

  initial begin
    int lat;
    logic [15:0] v, keep;
    void'($urandom(32'd7151));
    rst_ni = 0; cs_ni = 1; rd_ni = 1; wr_ni = 1; addr_latch_ni = 1; irq_i = 0;
    addr_i = '0; ad_i = '0;
    strap_muxed_i = 0; strap_swap_i = 0; strap_ack_late_i = 0; strap_async_i = 0;

    do_reset(0, 0, 0, 0);
    for (int i = 0; i < 64; i++) bus_write(12'(i), 16'($urandom), lat);

    // R2: async pin now high, captured strap low
    bus_write(12'h011, 16'h5a5a, lat);
    chk(lat == 2, "R2 pins ignored after reset", 16'(lat), 16'd2);

    // R3: written without swap, read back with swap
    bus_write(12'h007, 16'h1234, lat);
    do_reset(0, 1, 0, 0);
    bus_read(12'h007, v);
    chk(v == 16'h3412, "R3 byte exchange", v, 16'h3412);

    // R1: aliasing on bits above the store index, shared lane
    do_reset(1, 0, 1, 1);
    bus_write(12'h805, 16'hbeef, lat);
    bus_read(12'h005, v);
    chk(v == 16'hbeef, "R1 address alias", v, 16'hbeef);

    // R7: read strobe without select
    @(negedge clk); cs_ni = 1; rd_ni = 0;
    #1 chk(ad_oe_o == 1'b0, "R7 no drive unselected", 16'(ad_oe_o), 16'h0);
    @(negedge clk); rd_ni = 1;

    // R8: unselected write leaves store intact
    keep = model[9];
    ignored_write(12'h009, ~keep);
    bus_read(12'h009, v);
    chk(v == swp(keep, c_swap), "R8 store untouched", v, swp(keep, c_swap));

    irq_check();

    for (int cfg = 0; cfg < 16; cfg++) begin
      do_reset(cfg[0], cfg[1], cfg[2], cfg[3]);
      irq_check();
      for (int j = 0; j < 20; j++) begin
        int op = int'($urandom % 5);
        logic [11:0] a = 12'($urandom);
        if (op < 2) bus_write(a, 16'($urandom), lat);
        else if (op < 4) bus_read(a, v);
        else ignored_write(a, 16'($urandom));
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule